// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block is a calendar clock core. It holds the time as seven packed-BCD counters: seconds, minutes, hours, day of month, month, two-digit year, and a weekday. A one-second `tick` input advances the counters while the run bit is set. Software reaches all state through a byte-wide register port. The port has a 5-bit offset, a one-cycle write strobe and a combinational read path.

Software stops the clock, writes the time fields, and starts it again. Time reads are served from a shadow copy. A get-time command refreshes the shadow, so a burst of reads returns one consistent instant. A six-field alarm is compared against the time produced by each tick. A status byte collects the rollover events, the alarm flag and the power-up flag, and flags are cleared by writing ones. An enable byte turns on a periodic interrupt, an alarm interrupt, or both. A single `irq` output then gives a fresh rising edge for every enabled event.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the status byte (0x0E) reads 0x80, the control byte (0x0D) and interrupt-enable byte (0x0F) read 0x00, time reads return 00:00:00, day 01, month 01, year 00, weekday 0, and `irq` is low.
- R2: The counters advance on `tick` only while control bit 0 (run) is 1. Status bit 1 reads the run bit.
- R3: Seconds and minutes count 00 to 59 in BCD and carry into the next field on wrap. Hours count 00 to 23, and a units digit of 9 carries into the tens digit.
- R4: The day wraps to 01 after 31, 30, 29 or 28 according to the month. February has 29 days when the BCD year is divisible by 4, 00 included. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R5: The weekday (offset 0x06) counts 0 to 6 and advances only on a day rollover.
- R6: Writing control with bit 6 set copies the live counters into the read shadow. Offsets 0x00 to 0x06 return the shadow and do not change while the clock runs until the next such write. A write to a time offset loads the live counter.
- R7: Status bits 2, 3, 4 and 5 set on a running tick that produces a second, minute, hour or day rollover. A 1 written to any of status bits 2 to 7 clears that bit. A 0 leaves it unchanged.
- R8: The alarm registers sit at offsets 0x07 to 0x0C, in the order second, minute, hour, day, month, year. Status bit 6 sets on a running tick whose resulting time equals all six of them.
- R9: `irq` is high for exactly the one cycle after a running tick that carries an enabled event. Enable bit 3 enables the alarm match. Enable bit 2 enables the periodic event, whose period is chosen by bits 1:0: 00 every second, 01 minute, 10 hour, 11 day.
- R10: Offsets 0x10 to 0x1F read zero. Control reads back only its run bit. The enable byte reads back only bits 3:0.
- R11: The power-up flag (status bit 7) is set only by reset and is cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register offset for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt pulse, one cycle per enabled event |

## Verification
On every cycle the assertions check the following properties:
- A stopped clock leaves the seconds counter untouched.
- `irq`, a new alarm flag and a new day event each follow a running tick.
- A power-up clear sticks and the flag never sets again.

The calendar arithmetic can only be shown by the bench's scenarios, which load chosen times and read the result after a tick. This covers the carry chain, the month lengths and leap years, the weekday, snapshot coherence, the exact status bytes, and the choice of timer period.

// File: rtl/bcd_rtc.sv
module bcd_rtc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [4:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam logic [4:0] A_LAST_TIME  = 5'h06;
  localparam logic [4:0] A_LAST_ALARM = 5'h0C;
  localparam logic [4:0] A_CTRL       = 5'h0D;
  localparam logic [4:0] A_STAT       = 5'h0E;
  localparam logic [4:0] A_IEN        = 5'h0F;

  logic [7:0] tm_q [7];
  logic [7:0] sh_q [7];
  logic [7:0] al_q [6];
  logic [7:0] nx   [7];
  logic       run_q, alm_q, pwr_q, irq_q;
  logic [3:0] ie_q, ev_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v, input logic [7:0] top,
                                         input logic [7:0] base);
    if (v >= top) return base;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  wire        step = tick & run_q;
  wire [7:0]  yr   = tm_q[5];
  wire [7:0]  mon  = tm_q[4];
  wire        leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                           : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
  wire [7:0]  mdays = (mon == 8'h02) ? (leap ? 8'h29 : 8'h28) :
                      (mon == 8'h04 || mon == 8'h06 || mon == 8'h09 || mon == 8'h11) ? 8'h30 : 8'h31;

  wire c_min = tm_q[0] >= 8'h59;
  wire c_hr  = c_min & (tm_q[1] >= 8'h59);
  wire c_day = c_hr  & (tm_q[2] >= 8'h23);
  wire c_mon = c_day & (tm_q[3] >= mdays);
  wire c_yr  = c_mon & (mon >= 8'h12);

  always_comb begin
    nx[0] = bcd_inc(tm_q[0], 8'h59, 8'h00);
    nx[1] = c_min ? bcd_inc(tm_q[1], 8'h59, 8'h00) : tm_q[1];
    nx[2] = c_hr  ? bcd_inc(tm_q[2], 8'h23, 8'h00) : tm_q[2];
    nx[3] = c_day ? bcd_inc(tm_q[3], mdays, 8'h01) : tm_q[3];
    nx[4] = c_mon ? bcd_inc(tm_q[4], 8'h12, 8'h01) : tm_q[4];
    nx[5] = c_yr  ? bcd_inc(tm_q[5], 8'h99, 8'h00) : tm_q[5];
    nx[6] = c_day ? ((tm_q[6] >= 8'd6) ? 8'd0 : tm_q[6] + 8'd1) : tm_q[6];
  end

  wire match = (nx[0] == al_q[0]) && (nx[1] == al_q[1]) && (nx[2] == al_q[2]) &&
               (nx[3] == al_q[3]) && (nx[4] == al_q[4]) && (nx[5] == al_q[5]);

  logic thit;
  always_comb begin
    case (ie_q[1:0])
      2'd0:    thit = 1'b1;
      2'd1:    thit = c_min;
      2'd2:    thit = c_hr;
      default: thit = c_day;
    endcase
  end

  wire [2:0] al_idx = 3'(addr - 5'd7);
  wire       wr_tm  = wr_en && (addr <= A_LAST_TIME);
  wire       wr_al  = wr_en && (addr > A_LAST_TIME) && (addr <= A_LAST_ALARM);
  wire       wr_ctl = wr_en && (addr == A_CTRL);
  wire [7:0] clr    = (wr_en && addr == A_STAT) ? wr_data : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) begin
        tm_q[i] <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
        sh_q[i] <= (i == 3 || i == 4) ? 8'h01 : 8'h00;
      end
      for (int i = 0; i < 6; i++) al_q[i] <= 8'h00;
      run_q <= 1'b0;
      ie_q  <= 4'd0;
      ev_q  <= 4'd0;
      alm_q <= 1'b0;
      pwr_q <= 1'b1;
      irq_q <= 1'b0;
    end else begin
      if (step)
        for (int i = 0; i < 7; i++) tm_q[i] <= nx[i];
      if (wr_tm) tm_q[addr[2:0]] <= wr_data;
      if (wr_al) al_q[al_idx] <= wr_data;
      if (wr_ctl) begin
        run_q <= wr_data[0];
        if (wr_data[6])
          for (int i = 0; i < 7; i++) sh_q[i] <= tm_q[i];
      end
      if (wr_en && addr == A_IEN) ie_q <= wr_data[3:0];
      ev_q  <= (ev_q & ~clr[5:2]) | (step ? {c_day, c_hr, c_min, 1'b1} : 4'd0);
      alm_q <= (alm_q & ~clr[6]) | (step & match);
      pwr_q <= pwr_q & ~clr[7];
      irq_q <= step & ((ie_q[2] & thit) | (ie_q[3] & match));
    end
  end

  always_comb begin
    rd_data = 8'd0;
    if (addr <= A_LAST_TIME)       rd_data = sh_q[addr[2:0]];
    else if (addr <= A_LAST_ALARM) rd_data = al_q[al_idx];
    else if (addr == A_CTRL)       rd_data = {7'd0, run_q};
    else if (addr == A_STAT)       rd_data = {pwr_q, alm_q, ev_q, run_q, 1'b0};
    else if (addr == A_IEN)        rd_data = {4'd0, ie_q};
  end

  assign irq = irq_q;

  wire [7:0] sec_q = tm_q[0];

  assert_stop_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(wr_en && addr == 5'd0)) |=> $stable(sec_q));

  assert_irq_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(step));

  assert_alarm_from_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_q) |-> $past(step));

  assert_day_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_q[3]) |-> $past(step && tm_q[2] == 8'h23));

  assert_pwr_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_STAT && wr_data[7]) |=> !pwr_q);

  assert_pwr_no_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |=> !pwr_q);
endmodule

// File: tb/bcd_rtc_test.sv
module bcd_rtc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] addr = 5'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8:0] exp_q [$];
  string      tag_q [$];

  bcd_rtc uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
               .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #2 clk = ~clk;

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic snap();
    wr(5'h0D, 8'h41);
  endtask

  task automatic chk_rd(input logic [4:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; wr_en = 1'b0;
    exp_q.push_back({1'b0, e}); tag_q.push_back(tag);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    exp_q.push_back({1'b1, 7'd0, e}); tag_q.push_back(tag);
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo, y, w);
    wr(5'h0D, 8'h00);
    wr(5'h00, s); wr(5'h01, m); wr(5'h02, h); wr(5'h03, d);
    wr(5'h04, mo); wr(5'h05, y); wr(5'h06, w);
    wr(5'h0D, 8'h01);
  endtask

  task automatic roll_day(input logic [7:0] d, mo, y, ed, emo, input string tag);
    set_time(8'h59, 8'h59, 8'h23, d, mo, y, 8'h00);
    pulse_tick();
    snap();
    chk_rd(5'h03, ed, tag);
    chk_rd(5'h04, emo, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      while (exp_q.size() > 0) begin
        logic [8:0] it;
        logic [7:0] act;
        string t;
        it = exp_q.pop_front();
        t = tag_q.pop_front();
        act = it[8] ? {7'd0, irq} : rd_data;
        checks++;
        if (act !== it[7:0]) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, act, it[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_rd(5'h0E, 8'h80, "R1");
    chk_irq(1'b0, "R1");
    chk_rd(5'h0D, 8'h00, "R1");
    chk_rd(5'h0F, 8'h00, "R1");
    chk_rd(5'h00, 8'h00, "R1");
    chk_rd(5'h03, 8'h01, "R1");
    chk_rd(5'h04, 8'h01, "R1");
    // R10 read-back widths and unmapped space
    chk_rd(5'h10, 8'h00, "R10");
    chk_rd(5'h1F, 8'h00, "R10");
    wr(5'h0F, 8'hF3);
    chk_rd(5'h0F, 8'h03, "R10");
    wr(5'h0F, 8'h00);
    wr(5'h0D, 8'hBE);
    chk_rd(5'h0D, 8'h00, "R10");
    // R2 stopped clock ignores tick
    wr(5'h00, 8'h42);
    pulse_tick();
    wr(5'h0D, 8'h40);
    chk_rd(5'h00, 8'h42, "R2");
    chk_rd(5'h0E, 8'h80, "R2");
    wr(5'h0D, 8'h01);
    chk_rd(5'h0E, 8'h82, "R2");
    pulse_tick();
    snap();
    chk_rd(5'h00, 8'h43, "R2");
    // R7 / R11 write-one-clear
    wr(5'h0E, 8'h00);
    chk_rd(5'h0E, 8'h86, "R7");
    wr(5'h0E, 8'h80);
    chk_rd(5'h0E, 8'h06, "R11");
    wr(5'h0E, 8'h04);
    chk_rd(5'h0E, 8'h02, "R7");
    // R3 R4 R5 full rollover
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06);
    wr(5'h0E, 8'hFC);
    pulse_tick();
    chk_irq(1'b0, "R9");
    snap();
    chk_rd(5'h00, 8'h00, "R3");
    chk_rd(5'h01, 8'h00, "R3");
    chk_rd(5'h02, 8'h00, "R3");
    chk_rd(5'h03, 8'h01, "R4");
    chk_rd(5'h04, 8'h01, "R4");
    chk_rd(5'h05, 8'h00, "R4");
    chk_rd(5'h06, 8'h00, "R5");
    chk_rd(5'h0E, 8'h3E, "R7");
    // R6 snapshot coherence
    pulse_tick();
    chk_rd(5'h00, 8'h00, "R6");
    snap();
    chk_rd(5'h00, 8'h01, "R6");
    // R3 units-9 hour carry, day and weekday untouched
    set_time(8'h59, 8'h59, 8'h09, 8'h10, 8'h03, 8'h05, 8'h02);
    pulse_tick();
    snap();
    chk_rd(5'h02, 8'h10, "R3");
    chk_rd(5'h03, 8'h10, "R3");
    chk_rd(5'h06, 8'h02, "R5");
    // R4 month lengths and leap years
    roll_day(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R4");
    roll_day(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R4");
    roll_day(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R4");
    roll_day(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R4");
    roll_day(8'h28, 8'h02, 8'h12, 8'h29, 8'h02, "R4");
    roll_day(8'h30, 8'h04, 8'h25, 8'h01, 8'h05, "R4");
    roll_day(8'h30, 8'h05, 8'h25, 8'h31, 8'h05, "R4");
    // R8 alarm match
    set_time(8'h30, 8'h20, 8'h10, 8'h15, 8'h06, 8'h25, 8'h03);
    wr(5'h07, 8'h31); wr(5'h08, 8'h20); wr(5'h09, 8'h10);
    wr(5'h0A, 8'h15); wr(5'h0B, 8'h06); wr(5'h0C, 8'h25);
    chk_rd(5'h0C, 8'h25, "R8");
    wr(5'h0F, 8'h08);
    wr(5'h0E, 8'hFC);
    pulse_tick();
    chk_irq(1'b1, "R9");
    chk_rd(5'h0E, 8'h46, "R8");
    chk_irq(1'b0, "R9");
    pulse_tick();
    chk_irq(1'b0, "R8");
    // R9 periodic timer periods
    wr(5'h0F, 8'h05);
    pulse_tick();
    chk_irq(1'b0, "R9");
    wr(5'h00, 8'h59);
    pulse_tick();
    chk_irq(1'b1, "R9");
    wr(5'h0F, 8'h04);
    pulse_tick();
    chk_irq(1'b1, "R9");
    wr(5'h0F, 8'h06);
    pulse_tick();
    chk_irq(1'b0, "R9");
    wr(5'h01, 8'h59);
    wr(5'h00, 8'h59);
    pulse_tick();
    chk_irq(1'b1, "R9");
    wr(5'h0F, 8'h07);
    pulse_tick();
    chk_irq(1'b0, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule